// File: doc/BRIEF.md
# Per-Bit Addressed Control and Status Register

This block holds one 32-bit word of system control, status and error flags behind a simple memory-mapped bus. There is no single read/write location for the word. Each bit owns its own write address, and a write to that address either sets or clears the one bit. Whether the set or the clear is allowed depends on a fixed permission set for that bit. Hardware event pulses can also set the bits that accept them, and a synchronous system reset forces a chosen group of bits high and another group low.

A read anywhere in the 128-byte window returns the whole word. Every bit is also driven out continuously. The raw word is available, and so is a version in which the active-low bits are inverted, so that every bit of that output is 1 when its function is asserted. The rest of the system uses these levels as timer inhibits, floppy drive controls, an LED control and reset and shutdown requests. The bus and event pins are plain control pins with no handshake. A write or an event takes effect at the next rising clock edge, and read data is valid in the same cycle as the read strobe.

Top module: `csr_perbit_reg`

## Requirements
- R1: A write with byte offset `bus_addr` selects bit n = `bus_addr[6:2]` and ignores `bus_addr[1:0]`. `bus_wdata[0]` = 1 requests a set and 0 requests a clear. A write changes no bit other than bit n.
- R2: Status and error bits 0, 3, 4 and 23 to 30 are set only by their `hw_event` pulse. Software can clear them, and a software set has no effect on them.
- R3: Bits 1, 2 and 16 can be set by a `hw_event` pulse, set by software and cleared by software.
- R4: Bits 5, 6, 11, 12, 13, 14, 17, 18, 19, 21 and 22 change only through software set and clear. A `hw_event` pulse on any bit outside 0 to 4, 15, 16 and 23 to 30 has no effect.
- R5: Bits 7, 8, 9, 10 and 20 are set by `sys_rst`, and software can set and clear them.
- R6: Bit 15 is set by its `hw_event` pulse, cleared by software and cleared by `sys_rst`. A software set has no effect on it.
- R7: Bit 31 is set by software and cleared by `sys_rst`. A software clear has no effect on it.
- R8: During a cycle with `sys_rst` high, the register sets bits 7 to 10 and 20 and clears bits 15 and 31. It leaves all other bits unchanged and overrides any concurrent hardware event or software write.
- R9: If a hardware set and a software clear reach the same bit in the same cycle, the bit ends up set.
- R10: While `bus_sel` is high and `bus_we` is low, `bus_rdata` equals the full word in the same cycle, whatever the address. Otherwise `bus_rdata` is 0.
- R11: `csr_active` equals `csr_word` with bits 14, 17, 19 and 20 inverted.
- R12: Asynchronous `rst_n` low gives `csr_word` = 0x00100780 and `csr_active` = 0x000A4780.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset pulse |
| bus_sel | input | 1 | Bus access strobe for this window |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 7 | Byte offset within the window |
| bus_wdata | input | 32 | Write data; only bit 0 is used (set or clear) |
| bus_rdata | output | 32 | Read data, the whole word |
| hw_event | input | 32 | One-cycle hardware set pulses, one per bit |
| csr_word | output | 32 | Raw register word |
| csr_active | output | 32 | Per-bit asserted level (active-low bits inverted) |

## Verification
The main collision is a hardware event pulse and a software clear that target the same bit in the same cycle. The bench causes it by driving the pulse and the clear write on one clock edge, for a status bit and for a dual-source bit. Each bit must then read back as set. A second collision comes from raising `sys_rst` together with a hardware pulse on an unrelated status bit and a software clear on a reset-set bit. In that case the reset groups must take their forced values, and the bit hit by the pulse must keep its earlier value.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int NUM_BITS = 32;
  localparam int IDX_W    = $clog2(NUM_BITS);
  localparam int ADDR_W   = IDX_W + 2;

  // Per-bit permission masks (bit n of a mask governs register bit n)
  localparam logic [NUM_BITS-1:0] HW_SET_MASK  = 32'h7F81_801F;
  localparam logic [NUM_BITS-1:0] SW_SET_MASK  = 32'h807F_7FE6;
  localparam logic [NUM_BITS-1:0] SW_CLR_MASK  = 32'h7FFF_FFFF;
  localparam logic [NUM_BITS-1:0] RST_SET_MASK = 32'h0010_0780;
  localparam logic [NUM_BITS-1:0] RST_CLR_MASK = 32'h8000_8000;
  localparam logic [NUM_BITS-1:0] ACT_LO_MASK  = 32'h001A_4000;
endpackage

// File: rtl/csr_wr_decode.sv
module csr_wr_decode #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic          sel,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic          act_set,
  output logic [N-1:0]  set_stb,
  output logic [N-1:0]  clr_stb
);
  logic wr_go;
  assign wr_go = sel & we;

  for (genvar i = 0; i < N; i++) begin : g_stb
    logic hit;
    assign hit        = wr_go && (idx == IW'(i));
    assign set_stb[i] = hit &  act_set;
    assign clr_stb[i] = hit & ~act_set;
  end
endmodule

// File: rtl/csr_bit_cell.sv
module csr_bit_cell #(
  parameter bit CAN_HW_SET  = 1'b0,
  parameter bit CAN_SW_SET  = 1'b0,
  parameter bit CAN_SW_CLR  = 1'b0,
  parameter bit RST_FORCE_1 = 1'b0,
  parameter bit RST_FORCE_0 = 1'b0,
  parameter bit ACTIVE_LOW  = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sys_rst,
  input  logic hw_evt,
  input  logic sw_set,
  input  logic sw_clr,
  output logic q,
  output logic active
);
  logic q_nxt;
  logic hw_ok, set_ok, clr_ok;

  assign hw_ok  = hw_evt & CAN_HW_SET;
  assign set_ok = sw_set & CAN_SW_SET;
  assign clr_ok = sw_clr & CAN_SW_CLR;

  // Priority: system reset, hardware set, software set, software clear
  always_comb begin
    q_nxt = q;
    if (sys_rst) begin
      if (RST_FORCE_1)      q_nxt = 1'b1;
      else if (RST_FORCE_0) q_nxt = 1'b0;
    end else if (hw_ok || set_ok) begin
      q_nxt = 1'b1;
    end else if (clr_ok) begin
      q_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_FORCE_1;
    else        q <= q_nxt;
  end

  assign active = q ^ ACTIVE_LOW;
endmodule

// File: rtl/csr_perbit_reg.sv
module csr_perbit_reg
  import csr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sys_rst,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [NUM_BITS-1:0] bus_wdata,
  output logic [NUM_BITS-1:0] bus_rdata,
  input  logic [NUM_BITS-1:0] hw_event,
  output logic [NUM_BITS-1:0] csr_word,
  output logic [NUM_BITS-1:0] csr_active
);
  logic [NUM_BITS-1:0] set_stb, clr_stb;
  logic                unused_bits;

  assign unused_bits = ^{bus_wdata[NUM_BITS-1:1], bus_addr[1:0]};

  csr_wr_decode #(.N(NUM_BITS), .IW(IDX_W)) u_dec (
    .sel     (bus_sel),
    .we      (bus_we),
    .idx     (bus_addr[ADDR_W-1:2]),
    .act_set (bus_wdata[0]),
    .set_stb (set_stb),
    .clr_stb (clr_stb)
  );

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    csr_bit_cell #(
      .CAN_HW_SET  (HW_SET_MASK[i]),
      .CAN_SW_SET  (SW_SET_MASK[i]),
      .CAN_SW_CLR  (SW_CLR_MASK[i]),
      .RST_FORCE_1 (RST_SET_MASK[i]),
      .RST_FORCE_0 (RST_CLR_MASK[i]),
      .ACTIVE_LOW  (ACT_LO_MASK[i])
    ) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .sys_rst (sys_rst),
      .hw_evt  (hw_event[i]),
      .sw_set  (set_stb[i]),
      .sw_clr  (clr_stb[i]),
      .q       (csr_word[i]),
      .active  (csr_active[i])
    );
  end

  assign bus_rdata = (bus_sel && !bus_we) ? csr_word : '0;
endmodule

// File: rtl/csr_perbit_chk.sv
module csr_perbit_chk
  import csr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                sys_rst,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [NUM_BITS-1:0] bus_rdata,
  input logic [NUM_BITS-1:0] hw_event,
  input logic [NUM_BITS-1:0] csr_word
);
  logic [NUM_BITS-1:0] hw_live;
  assign hw_live = hw_event & HW_SET_MASK;

  a_r9_hw_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && (hw_live != '0)) |=> ((csr_word & $past(hw_live)) == $past(hw_live)));

  a_r8_reset_groups: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> (((csr_word & RST_SET_MASK) == RST_SET_MASK) && ((csr_word & RST_CLR_MASK) == '0)));

  a_r8_reset_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> ((csr_word & ~(RST_SET_MASK | RST_CLR_MASK)) ==
                 ($past(csr_word) & ~(RST_SET_MASK | RST_CLR_MASK))));

  a_r2_no_sw_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && (hw_live == '0)) |=> ((csr_word & ~$past(csr_word) & ~SW_SET_MASK) == '0));

  a_r7_no_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_rst |=> !($past(csr_word[NUM_BITS-1]) && !csr_word[NUM_BITS-1]));

  a_r1_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (!sys_rst && (hw_live == '0)) |=> ($countones(csr_word ^ $past(csr_word)) <= 1));

  a_r10_read_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we) |-> (bus_rdata == csr_word));
endmodule

bind csr_perbit_reg csr_perbit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sys_rst   (sys_rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .hw_event  (hw_event),
  .csr_word  (csr_word)
);

// File: tb/csr_perbit_reg_bench.sv
`timescale 1ns/100ps
module csr_perbit_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_rst = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] hw_event = '0;
  logic [31:0] csr_word;
  logic [31:0] csr_active;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_w;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csr_perbit_reg u_csr_perbit_reg (
    .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .hw_event(hw_event), .csr_word(csr_word),
    .csr_active(csr_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  // One clock edge with the given stimulus, then sampled at the next negedge
  task automatic cycle(input bit wr, input int idx, input bit v, input logic [1:0] lo,
                       input logic [31:0] hw, input bit sr);
    @(negedge clk);
    bus_sel = wr; bus_we = wr; bus_addr = {idx[4:0], lo};
    bus_wdata = {31'h5A5A_5A5A, v}; hw_event = hw; sys_rst = sr;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; hw_event = '0; sys_rst = 0;
  endtask

  task automatic wr(input int idx, input bit v);
    cycle(1'b1, idx, v, 2'b00, 32'h0, 1'b0);
  endtask

  task automatic pulse(input logic [31:0] hw);
    cycle(1'b0, 0, 1'b0, 2'b00, hw, 1'b0);
  endtask

  task automatic rd_check(input string req, input logic [6:0] a);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 check(req, bus_rdata, exp_w);
    bus_sel = 0; bus_addr = '0;
  endtask

  task automatic t_reset;
    exp_w = 32'h0010_0780;
    check("R12 word after rst_n", csr_word, exp_w);
    check("R12 active after rst_n", csr_active, 32'h000A_4780);
    rd_check("R10 read offset 0x35", 7'h35);
    rd_check("R10 read offset 0x7F", 7'h7F);
  endtask

  task automatic t_status;
    wr(0, 1);                                  check("R2 sw set bit0 ignored", csr_word, exp_w);
    pulse(32'h1);         exp_w[0] = 1'b1;     check("R2 hw set bit0", csr_word, exp_w);
    wr(27, 1);                                 check("R2 sw set bit27 ignored", csr_word, exp_w);
    pulse(32'h0800_0000); exp_w[27] = 1'b1;    check("R2 hw set bit27", csr_word, exp_w);
    cycle(1'b1, 27, 1'b0, 2'b11, 32'h0, 1'b0);
    exp_w[27] = 1'b0;                          check("R1 low addr bits ignored, clear bit27", csr_word, exp_w);
    wr(0, 0);             exp_w[0] = 1'b0;     check("R2 sw clear bit0", csr_word, exp_w);
  endtask

  task automatic t_dual;
    wr(16, 1);            exp_w[16] = 1'b1;    check("R3 sw set bit16", csr_word, exp_w);
    wr(16, 0);            exp_w[16] = 1'b0;    check("R3 sw clear bit16", csr_word, exp_w);
    pulse(32'h0001_0000); exp_w[16] = 1'b1;    check("R3 hw set bit16", csr_word, exp_w);
    wr(16, 0);            exp_w[16] = 1'b0;    check("R3 clear bit16 again", csr_word, exp_w);
  endtask

  task automatic t_swonly;
    wr(12, 1);            exp_w[12] = 1'b1;    check("R1 only bit12 set", csr_word, exp_w);
    pulse(32'h8000_2060);                      check("R4 hw on non-capable bits ignored", csr_word, exp_w);
    wr(12, 0);            exp_w[12] = 1'b0;    check("R4 sw clear bit12", csr_word, exp_w);
    wr(12, 1);            exp_w[12] = 1'b1;    check("R4 sw set bit12", csr_word, exp_w);
  endtask

  task automatic t_resetset;
    wr(7, 0);             exp_w[7] = 1'b0;     check("R5 sw clear bit7", csr_word, exp_w);
    wr(20, 0);            exp_w[20] = 1'b0;    check("R5 sw clear bit20", csr_word, exp_w);
    check("R11 active bit20 with bit cleared", {31'h0, csr_active[20]}, 32'h1);
    wr(20, 1);            exp_w[20] = 1'b1;    check("R5 sw set bit20", csr_word, exp_w);
    check("R11 active bit20 with bit set", {31'h0, csr_active[20]}, 32'h0);
    wr(14, 1);            exp_w[14] = 1'b1;
    check("R11 active word", csr_active, exp_w ^ 32'h001A_4000);
    wr(14, 0);            exp_w[14] = 1'b0;    check("R4 sw clear bit14", csr_word, exp_w);
  endtask

  task automatic t_thermal;
    wr(15, 1);                                 check("R6 sw set bit15 ignored", csr_word, exp_w);
    pulse(32'h0000_8000); exp_w[15] = 1'b1;    check("R6 hw set bit15", csr_word, exp_w);
    wr(15, 0);            exp_w[15] = 1'b0;    check("R6 sw clear bit15", csr_word, exp_w);
    pulse(32'h0000_8000); exp_w[15] = 1'b1;    check("R6 hw set bit15 again", csr_word, exp_w);
  endtask

  task automatic t_request;
    wr(31, 1);            exp_w[31] = 1'b1;    check("R7 sw set bit31", csr_word, exp_w);
    wr(31, 0);                                 check("R7 sw clear bit31 ignored", csr_word, exp_w);
  endtask

  task automatic t_sysrst;
    // sys_rst with a concurrent hw pulse on bit0 and a sw clear of bit8
    cycle(1'b1, 8, 1'b0, 2'b00, 32'h0000_0001, 1'b1);
    exp_w = (exp_w | 32'h0010_0780) & ~32'h8000_8000;
    check("R8 sys_rst groups and override", csr_word, exp_w);
    check("R6 sys_rst clears bit15", {31'h0, csr_word[15]}, 32'h0);
    check("R7 sys_rst clears bit31", {31'h0, csr_word[31]}, 32'h0);
    check("R5 sys_rst sets bit7", {31'h0, csr_word[7]}, 32'h1);
  endtask

  task automatic t_collide;
    cycle(1'b1, 3, 1'b0, 2'b00, 32'h0000_0008, 1'b0);
    exp_w[3] = 1'b1;                           check("R9 hw set beats clear bit3", csr_word, exp_w);
    cycle(1'b1, 1, 1'b0, 2'b00, 32'h0000_0002, 1'b0);
    exp_w[1] = 1'b1;                           check("R9 hw set beats clear bit1", csr_word, exp_w);
    wr(3, 0); wr(1, 0);   exp_w[3] = 1'b0; exp_w[1] = 1'b0;
    check("R9 bits clear after collision", csr_word, exp_w);
  endtask

  task automatic t_read;
    rd_check("R10 read offset 0x00", 7'h00);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 7'h30; bus_wdata = 32'h1;
    #1 check("R10 rdata zero during write", bus_rdata, 32'h0);
    @(negedge clk);
    bus_sel = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    exp_w[12] = 1'b1;
    #1 check("R10 rdata zero when unselected", bus_rdata, 32'h0);
  endtask

  task automatic t_async;
    wr(31, 1);
    #1 rst_n = 0;
    #1 check("R12 async reset word", csr_word, 32'h0010_0780);
    check("R12 async reset active", csr_active, 32'h000A_4780);
    @(negedge clk) rst_n = 1;
    exp_w = 32'h0010_0780;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_status();
    t_dual();
    t_swonly();
    t_resetset();
    t_thermal();
    t_request();
    t_sysrst();
    t_collide();
    t_read();
    t_async();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule